// File: doc/BRIEF.md
# Two-Bit Branch Predictor With Static Seeding

This block guesses the direction of conditional relative branches for a pipelined 8-bit processor. It keeps a direct-mapped table of 2-bit saturating counters, and each branch address selects one entry. On a lookup the fetch stage presents the branch address and its signed 8-bit displacement. The block answers in the same cycle with a taken/not-taken guess and a flag that says whether the table held a trained entry for that address.

When the table has no entry for a branch, a fixed rule based on the displacement decides the guess. A one-bit select input picks between two rules:

- **Rule 0:** backward branches are taken and all forward branches are not taken.
- **Rule 1:** backward branches are taken, and forward branches that skip one to five bytes are also taken. The short forward case suits the carry-adjust idiom of 16-bit arithmetic on an 8-bit machine.

When the branch resolves, the pipeline sends its address, displacement and actual outcome. A missing entry is then allocated and seeded from the same rule, and the counter is stepped toward the outcome. After that first resolve, only the counter decides the guess.

Top module: `branch_pred2b`

## Requirements
- R1: After reset every table entry is empty, so every lookup reports predHit = 0 until a resolve has written that entry; a reset asserted later empties the table again.
- R2: On a lookup miss with ruleSel = 0, predTaken is 1 exactly when lkDisp bit 7 is 1 (negative displacement). A displacement of 0 or any positive value gives 0.
- R3: On a lookup miss with ruleSel = 1, predTaken is 1 when lkDisp is negative or lies in 1..5. A displacement of 0 or 6..127 gives 0.
- R4: A resolve (updValid = 1) whose address misses the table writes the entry at index updPc[5:0], with tag updPc[15:6]. The counter is seeded to 2 if the static rule chosen by ruleSel, applied to updDisp, says taken, and to 1 otherwise. The seed is then moved one step toward updTaken.
- R5: A resolve that hits the table adds 1 to the counter on a taken outcome, stopping at 3. It subtracts 1 on a not-taken outcome, stopping at 0.
- R6: On a lookup hit, predTaken is 1 exactly when the counter is 2 or 3. Neither ruleSel nor lkDisp has any effect on the guess.
- R7: A hit requires the stored tag to equal lkPc[15:6]. An address that shares index bits with a stored branch but has a different tag misses, and resolving it replaces the older entry.
- R8: When a lookup and a resolve address the same entry in the same cycle, the lookup returns the guess and hit flag held before that resolve. The new state is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| ruleSel | input | 1 | Static rule: 0 backward-only taken, 1 also short forward taken |
| lkPc | input | 16 | Branch address being looked up |
| lkDisp | input | 8 | Signed displacement of the looked-up branch |
| predTaken | output | 1 | Predicted direction for the lookup (1 = taken) |
| predHit | output | 1 | Lookup found a valid entry with a matching tag |
| updValid | input | 1 | A branch has resolved this cycle |
| updPc | input | 16 | Address of the resolved branch |
| updDisp | input | 8 | Displacement of the resolved branch, used for seeding |
| updTaken | input | 1 | Actual outcome of the resolved branch |

## Verification
A wrong seed or a counter that steps wrongly does not show on the cycle of the resolve. It appears on the next lookup of that address, one clock later, as a flipped predTaken. Some counter faults only surface after one or two further resolves move the counter across the 1/2 boundary. For that reason, the directed cases follow a single seed with a not-taken outcome, and they drive the counter past both saturation ends before reading it back. Tag or valid corruption shows directly on predHit at the next lookup of an aliased or freshly reset address. The same-cycle case checks that the guess reflects the state held before the write.

// File: rtl/bp_pkg.sv
package bp_pkg;

  localparam int PC_W          = 16;
  localparam int IDX_W         = 6;
  localparam int TAG_W         = PC_W - IDX_W;
  localparam int ENTRIES       = 1 << IDX_W;
  localparam int DISP_W        = 8;
  localparam int CNT_W         = 2;
  localparam int SHORT_FWD_MAX = 5;

  localparam logic [CNT_W-1:0] CNT_MAX    = '1;
  localparam logic [CNT_W-1:0] CNT_MIN    = '0;
  localparam logic [CNT_W-1:0] SEED_TAKEN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] SEED_NOT   = {1'b0, {(CNT_W-1){1'b1}}};

  typedef enum logic [0:0] {
    RULE_BACK_ONLY = 1'b0,
    RULE_SHORT_FWD = 1'b1
  } staticRule_e;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] tag;
    logic [CNT_W-1:0] cnt;
  } entry_t;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic [CNT_W-1:0] cnt;
  } wrStrobe_t;

  function automatic logic staticTaken(input logic [DISP_W-1:0] disp,
                                       input staticRule_e rule);
    logic isBack;
    logic isShortFwd;
    isBack     = disp[DISP_W-1];
    isShortFwd = !isBack && (disp != '0) && (disp <= DISP_W'(SHORT_FWD_MAX));
    return isBack || ((rule == RULE_SHORT_FWD) && isShortFwd);
  endfunction

  function automatic logic [CNT_W-1:0] satStep(input logic [CNT_W-1:0] cnt,
                                               input logic taken);
    logic [CNT_W-1:0] nxt;
    if (taken) nxt = (cnt == CNT_MAX) ? cnt : cnt + CNT_W'(1);
    else       nxt = (cnt == CNT_MIN) ? cnt : cnt - CNT_W'(1);
    return nxt;
  endfunction

endpackage

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] lkIdx,
  input  logic [IDX_W-1:0] updIdx,
  input  wrStrobe_t        wr,
  output entry_t           lkEntry,
  output entry_t           updEntry
);

  logic             validArr [ENTRIES];
  logic [TAG_W-1:0] tagArr   [ENTRIES];
  logic [CNT_W-1:0] cntArr   [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic selHere;
    assign selHere = wr.en && (wr.idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        validArr[g] <= 1'b0;
      else if (selHere) validArr[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (selHere) begin
        tagArr[g] <= wr.tag;
        cntArr[g] <= wr.cnt;
      end
    end
  end

  always_comb begin
    lkEntry.valid  = validArr[lkIdx];
    lkEntry.tag    = tagArr[lkIdx];
    lkEntry.cnt    = cntArr[lkIdx];
    updEntry.valid = validArr[updIdx];
    updEntry.tag   = tagArr[updIdx];
    updEntry.cnt   = cntArr[updIdx];
  end

  // R4: a write strobe leaves a valid entry holding the written counter and tag
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wr.en)) |->
      (validArr[$past(wr.idx)] && cntArr[$past(wr.idx)] == $past(wr.cnt)
       && tagArr[$past(wr.idx)] == $past(wr.tag)));

endmodule

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ruleSel,
  input  logic [PC_W-1:0]   lkPc,
  input  logic [DISP_W-1:0] lkDisp,
  input  logic              updValid,
  input  logic [PC_W-1:0]   updPc,
  input  logic [DISP_W-1:0] updDisp,
  input  logic              updTaken,
  input  entry_t            lkEntry,
  input  entry_t            updEntry,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [IDX_W-1:0]  updIdx,
  output wrStrobe_t         wr,
  output logic              predTaken,
  output logic              predHit
);

  staticRule_e      rule;
  logic [TAG_W-1:0] lkTag;
  logic [TAG_W-1:0] updTag;
  logic             lkMatch;
  logic             updMatch;
  logic             lkStatic;
  logic             updStatic;
  logic [CNT_W-1:0] baseCnt;

  assign rule = staticRule_e'(ruleSel);

  // lookup side
  assign lkIdx    = lkPc[IDX_W-1:0];
  assign lkTag    = lkPc[PC_W-1:IDX_W];
  assign lkMatch  = lkEntry.valid && (lkEntry.tag == lkTag);
  assign lkStatic = staticTaken(lkDisp, rule);

  assign predHit   = lkMatch;
  assign predTaken = lkMatch ? lkEntry.cnt[CNT_W-1] : lkStatic;

  // resolve side
  assign updIdx    = updPc[IDX_W-1:0];
  assign updTag    = updPc[PC_W-1:IDX_W];
  assign updMatch  = updEntry.valid && (updEntry.tag == updTag);
  assign updStatic = staticTaken(updDisp, rule);

  always_comb begin
    if (updMatch)       baseCnt = updEntry.cnt;
    else if (updStatic) baseCnt = SEED_TAKEN;
    else                baseCnt = SEED_NOT;
    wr.en  = updValid;
    wr.idx = updIdx;
    wr.tag = updTag;
    wr.cnt = satStep(baseCnt, updTaken);
  end

  // R2: a miss on a backward branch is guessed taken under either rule
  assert_miss_backward_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!predHit && lkDisp[DISP_W-1]) |-> predTaken);

  // R3: a zero displacement miss is never guessed taken
  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!predHit && lkDisp == '0) |-> !predTaken);

  // R4: a freshly seeded counter lands on the side of the outcome
  assert_seed_side_R4: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updMatch) |->
      (updTaken ? (wr.cnt >= SEED_TAKEN) : (wr.cnt <= SEED_NOT)));

  // R5: a saturated counter does not wrap
  assert_sat_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updMatch && updTaken && updEntry.cnt == CNT_MAX) |-> (wr.cnt == CNT_MAX));
  assert_sat_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updMatch && !updTaken && updEntry.cnt == CNT_MIN) |-> (wr.cnt == CNT_MIN));

  // R6: a hit guess agrees with the upper half of the counter range
  assert_hit_guess_R6: assert property (@(posedge clk) disable iff (!rstN)
    predHit |-> (predTaken == (lkEntry.cnt >= SEED_TAKEN)));

endmodule

// File: rtl/branch_pred2b.sv
module branch_pred2b
  import bp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ruleSel,
  input  logic [PC_W-1:0]   lkPc,
  input  logic [DISP_W-1:0] lkDisp,
  output logic              predTaken,
  output logic              predHit,
  input  logic              updValid,
  input  logic [PC_W-1:0]   updPc,
  input  logic [DISP_W-1:0] updDisp,
  input  logic              updTaken
);

  logic [IDX_W-1:0] lkIdx;
  logic [IDX_W-1:0] updIdx;
  wrStrobe_t        wr;
  entry_t           lkEntry;
  entry_t           updEntry;

  bp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ruleSel  (ruleSel),
    .lkPc     (lkPc),
    .lkDisp   (lkDisp),
    .updValid (updValid),
    .updPc    (updPc),
    .updDisp  (updDisp),
    .updTaken (updTaken),
    .lkEntry  (lkEntry),
    .updEntry (updEntry),
    .lkIdx    (lkIdx),
    .updIdx   (updIdx),
    .wr       (wr),
    .predTaken(predTaken),
    .predHit  (predHit)
  );

  bp_table u_table (
    .clk     (clk),
    .rstN    (rstN),
    .lkIdx   (lkIdx),
    .updIdx  (updIdx),
    .wr      (wr),
    .lkEntry (lkEntry),
    .updEntry(updEntry)
  );

endmodule

// File: tb/branch_pred2b_tb.sv
`timescale 1ns/1ps
module branch_pred2b_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ruleSel = 1'b0;
  logic [15:0] lkPc = '0;
  logic [7:0]  lkDisp = '0;
  logic        predTaken;
  logic        predHit;
  logic        updValid = 1'b0;
  logic [15:0] updPc = '0;
  logic [7:0]  updDisp = '0;
  logic        updTaken = 1'b0;

  always #10 clk = ~clk;

  branch_pred2b u_dut (
    .clk(clk), .rstN(rstN), .ruleSel(ruleSel), .lkPc(lkPc), .lkDisp(lkDisp),
    .predTaken(predTaken), .predHit(predHit), .updValid(updValid),
    .updPc(updPc), .updDisp(updDisp), .updTaken(updTaken)
  );

  typedef struct {
    bit    pred;
    bit    hit;
    string req;
  } expItem_t;

  expItem_t scoreQ[$];
  int checks = 0;
  int fails = 0;
  bit doneFlag = 0;

  bit       refValid [64];
  bit [9:0] refTag   [64];
  int       refCnt   [64];

  function automatic bit refStatic(input logic [7:0] d, input bit rule);
    if (d[7]) return 1;
    if (rule && d >= 8'd1 && d <= 8'd5) return 1;
    return 0;
  endfunction

  task automatic clearModel();
    for (int i = 0; i < 64; i++) begin
      refValid[i] = 0; refTag[i] = '0; refCnt[i] = 0;
    end
  endtask

  task automatic step(input bit doLk, input logic [15:0] lp, input logic [7:0] ld,
                      input bit doUp, input logic [15:0] up, input logic [7:0] ud,
                      input bit ut, input bit rule, input string req);
    @(negedge clk);
    ruleSel = rule; lkPc = lp; lkDisp = ld;
    updValid = doUp; updPc = up; updDisp = ud; updTaken = ut;
    if (doLk) begin
      int li;
      expItem_t e;
      li = int'(lp[5:0]);
      e.hit  = refValid[li] && (refTag[li] == lp[15:6]);
      e.pred = e.hit ? (refCnt[li] >= 2) : refStatic(ld, rule);
      e.req  = req;
      scoreQ.push_back(e);
    end
    @(posedge clk);
    if (doUp) begin
      int ui;
      int c;
      ui = int'(up[5:0]);
      if (refValid[ui] && refTag[ui] == up[15:6]) c = refCnt[ui];
      else c = refStatic(ud, rule) ? 2 : 1;
      if (ut) c = (c == 3) ? 3 : c + 1;
      else    c = (c == 0) ? 0 : c - 1;
      refValid[ui] = 1; refTag[ui] = up[15:6]; refCnt[ui] = c;
    end
  endtask

  task automatic look(input logic [15:0] lp, input logic [7:0] ld, input bit rule, input string req);
    step(1, lp, ld, 0, '0, '0, 0, rule, req);
  endtask

  task automatic resolve(input logic [15:0] up, input logic [7:0] ud, input bit ut, input bit rule);
    step(0, '0, '0, 1, up, ud, ut, rule, "");
  endtask

  task automatic idle();
    @(negedge clk);
    updValid = 0;
  endtask

  // monitor: compare outputs against queued expectations away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (scoreQ.size() > 0) begin
        expItem_t e;
        e = scoreQ.pop_front();
        checks++;
        if (predTaken !== e.pred || predHit !== e.hit) begin
          fails++;
          $display("FAIL %s: pred=%0b hit=%0b expected pred=%0b hit=%0b (lkPc=%h lkDisp=%h)",
                   e.req, predTaken, predHit, e.pred, e.hit, lkPc, lkDisp);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!doneFlag) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    clearModel();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1: empty after reset
    look(16'h0000, 8'h00, 0, "R1");
    look(16'h1234, 8'hF0, 1, "R1");
    look(16'hFFFF, 8'h03, 0, "R1");

    // R2: rule 0 miss guesses
    look(16'h0100, 8'hFD, 0, "R2");
    look(16'h0101, 8'h80, 0, "R2");
    look(16'h0102, 8'h00, 0, "R2");
    look(16'h0103, 8'h03, 0, "R2");
    look(16'h0104, 8'h7F, 0, "R2");

    // R3: rule 1 miss guesses, both ends of the short window
    look(16'h0200, 8'h80, 1, "R3");
    look(16'h0201, 8'h00, 1, "R3");
    look(16'h0202, 8'h01, 1, "R3");
    look(16'h0203, 8'h05, 1, "R3");
    look(16'h0204, 8'h06, 1, "R3");
    look(16'h0205, 8'h7F, 1, "R3");

    // R4: seed from rule 1 short forward (2) then taken -> 3
    resolve(16'h1234, 8'h03, 1, 1);
    look(16'h1234, 8'h40, 0, "R4");
    // R4: seed from rule 0 forward (1) then taken -> 2, then not taken -> 1
    resolve(16'h0C0A, 8'h0A, 1, 0);
    look(16'h0C0A, 8'h0A, 0, "R4");
    resolve(16'h0C0A, 8'h0A, 0, 0);
    look(16'h0C0A, 8'h0A, 0, "R4");
    // R4: seed backward (2) then not taken -> 1
    resolve(16'h0411, 8'hF8, 0, 0);
    look(16'h0411, 8'hF8, 0, "R4");
    // R4: same displacement, rule 1 seeds 2, rule 0 would seed 1
    resolve(16'h0812, 8'h04, 0, 1);
    look(16'h0812, 8'h04, 1, "R4");
    resolve(16'h0812, 8'h04, 1, 1);
    look(16'h0812, 8'h04, 1, "R4");

    // R5: saturate high then one not taken stays taken
    for (int k = 0; k < 5; k++) resolve(16'h0020, 8'h10, 1, 0);
    resolve(16'h0020, 8'h10, 0, 0);
    look(16'h0020, 8'h10, 0, "R5");
    resolve(16'h0020, 8'h10, 0, 0);
    look(16'h0020, 8'h10, 0, "R5");
    // saturate low then one taken stays not taken
    for (int k = 0; k < 5; k++) resolve(16'h0020, 8'h10, 0, 0);
    resolve(16'h0020, 8'h10, 1, 0);
    look(16'h0020, 8'h10, 0, "R5");
    resolve(16'h0020, 8'h10, 1, 0);
    look(16'h0020, 8'h10, 0, "R5");

    // R6: hit guess ignores rule and displacement (entry 0x0020 now 2)
    look(16'h0020, 8'h00, 1, "R6");
    look(16'h0020, 8'h7F, 0, "R6");
    resolve(16'h0020, 8'h10, 0, 0);
    resolve(16'h0020, 8'h10, 0, 0);
    look(16'h0020, 8'hF0, 0, "R6");
    look(16'h0020, 8'h02, 1, "R6");

    // R7: alias on index 0x34 with a different tag misses, then replaces
    look(16'hA234, 8'h10, 0, "R7");
    resolve(16'hA234, 8'h10, 0, 0);
    look(16'hA234, 8'h10, 0, "R7");
    look(16'h1234, 8'h10, 0, "R7");

    // R8: lookup and resolve on the same entry in one cycle
    step(1, 16'h0C0A, 8'h0A, 1, 16'h0C0A, 8'h0A, 1, 0, "R8");
    look(16'h0C0A, 8'h0A, 0, "R8");
    step(1, 16'h3F3F, 8'hF0, 1, 16'h3F3F, 8'hF0, 0, 0, "R8");
    look(16'h3F3F, 8'hF0, 0, "R8");

    // mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      logic [15:0] b;
      a = 16'((($urandom % 3) << 6) | ($urandom % 8));
      b = 16'((($urandom % 3) << 6) | ($urandom % 8));
      step(1, a, 8'($urandom), ($urandom % 2) == 0, b, 8'($urandom),
           ($urandom % 2) == 0, ($urandom % 2) == 0, "R5");
    end
    idle();

    // R1: reset mid-run empties trained entries
    @(negedge clk) rstN = 0;
    clearModel();
    repeat (2) @(negedge clk);
    rstN = 1;
    look(16'h0020, 8'h10, 0, "R1");
    look(16'h0C0A, 8'h0A, 1, "R1");
    idle();
    repeat (3) @(negedge clk);

    doneFlag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule